// File: doc/BRIEF.md
# Registered Two-Way Transfer Port with Parity Flags

This block moves bytes between two buses, called side A and side B, through a storage register for each direction. The forward register captures side-A data and presents it on side B together with a generated parity bit. The return register captures side-B data and the incoming parity bit, presents the data on side A and reports a parity error. Each direction has its own load strobe, active-low load enable, active-low drive enable and status flag. A producer loads a register, which raises that direction's flag. The consumer reads the port by pulling its drive enable low, and clears the flag when it releases that enable.

The bidirectional pins are split into separate input, output and drive-enable signals for the surrounding pad logic. All state sits on one system clock. The per-direction strobes and the drive-enable release edges are found by comparing each input with its value one system clock earlier.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-high reset `rst` clears both data registers, the return parity register and both flags. After reset, `r_full` and `s_full` are 0, and both data outputs read 0 when driven.
- R2: In a clock cycle where `r_strobe` is 1 and was 0 in the previous cycle, and `r_load_n` is 0, the forward register captures `a_in` at that clock edge. In every other cycle it keeps its contents.
- R3: The same capture rule applies to the return register with `s_strobe`/`s_load_n`: it captures `b_in`, and it captures `pbit_in` into the one-bit parity register at the same edge.
- R4: A capture into a register sets that direction's flag (`r_full` or `s_full`) to 1 from the following cycle onward.
- R5: `r_full` clears after a cycle in which `b_out_n` is 1 and was 0 in the previous cycle. `s_full` clears in the same way on `a_out_n`. Otherwise each flag holds.
- R6: When a capture and a flag-clearing edge fall in the same cycle, the flag ends up set.
- R7: `b_drive` and `pbit_drive` equal the inverse of `b_out_n`. `b_out` shows the forward register contents.
- R8: `pbit_out` is 1 when the forward register holds an even number of ones (all zeros included), and 0 otherwise.
- R9: `a_drive` equals the inverse of `a_out_n`. `a_out` shows the return register contents.
- R10: While `a_out_n` is 0, `perr_n` is 1 when the return register plus the parity register hold an odd number of ones, and 0 when they hold an even number. While `a_out_n` is 1, `perr_n` is 1.
- R11: A strobe held at 1 over several cycles causes exactly one capture. Data changes after the first cycle are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DATA_W | Side-A pin input (forward data source) |
| a_out | output | DATA_W | Side-A pin output (return register) |
| a_drive | output | 1 | Side-A pin drive enable |
| b_in | input | DATA_W | Side-B pin input (return data source) |
| b_out | output | DATA_W | Side-B pin output (forward register) |
| b_drive | output | 1 | Side-B pin drive enable |
| pbit_in | input | 1 | Parity pin input, captured with return data |
| pbit_out | output | 1 | Generated parity of forward register |
| pbit_drive | output | 1 | Parity pin drive enable |
| r_strobe | input | 1 | Forward load strobe, rising edge active |
| r_load_n | input | 1 | Forward load enable, active low |
| s_strobe | input | 1 | Return load strobe, rising edge active |
| s_load_n | input | 1 | Return load enable, active low |
| b_out_n | input | 1 | Side-B drive enable, active low; rising edge clears `r_full` |
| a_out_n | input | 1 | Side-A drive enable, active low; rising edge clears `s_full` |
| r_full | output | 1 | Forward register status flag |
| s_full | output | 1 | Return register status flag |
| perr_n | output | 1 | Parity check result, active low |

## Verification
The assertions assume that the strobes, load enables and drive enables are already synchronous to `clk` and stable around each edge, and that they stay at rest (strobes 0, drive enables 1) during reset, so no false edge appears when reset is released. The bench changes every input one time unit after a rising clock edge and holds the strobes low through reset. Each strobe pulse lasts at least one full clock cycle, so each pulse produces exactly one detected edge. All 256 forward bytes and all 512 return byte/parity combinations are swept. Hold, held-strobe, flag-release and collision cases are then applied separately.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   // Variant selector for one transfer direction
   typedef enum logic [0:0] {
      LANE_GEN = 1'b0,   // parity generated from stored data
      LANE_CHK = 1'b1    // parity captured and checked
   } lane_kind_e;

   // Odd-parity helper: 1 when the vector has an even number of ones
   function automatic logic even_ones(input logic [63:0] v, input int unsigned w);
      logic acc;
      acc = 1'b1;
      for (int unsigned i = 0; i < w; i++) acc = acc ^ v[i];
      return acc;
   endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
   input  logic clk,
   input  logic sig_i,
   output logic rise_o
);

   // Previous sample tracks the input in every cycle, including reset,
   // so a level already present at reset release never looks like an edge.
   logic prev_q;

   always_ff @(posedge clk) begin
      prev_q <= sig_i;
   end

   assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter lane_kind_e  KIND   = LANE_GEN
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] d_i,
   input  logic              par_i,
   output logic [DATA_W-1:0] q_o,
   output logic              q_oe_o,
   output logic              flag_o,
   output logic              par_o,
   output logic              par_oe_o,
   output logic              err_n_o
);

   localparam int unsigned FULL_W = DATA_W + 1;

   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("xcvr_lane: DATA_W must be between 1 and 64");
   end

   logic stb_rise;
   logic oe_rise;
   logic load;
   logic [DATA_W-1:0] data_q;
   logic flag_q;

   xcvr_edge i_stb_edge (.clk(clk), .sig_i(stb_i),  .rise_o(stb_rise));
   xcvr_edge i_oe_edge  (.clk(clk), .sig_i(oe_n_i), .rise_o(oe_rise));

   assign load = stb_rise & ~ce_n_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
      end else if (load) begin
         data_q <= d_i;
      end
   end

   // Set has priority over clear
   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= 1'b0;
      end else if (load) begin
         flag_q <= 1'b1;
      end else if (oe_rise) begin
         flag_q <= 1'b0;
      end
   end

   assign q_o    = data_q;
   assign q_oe_o = ~oe_n_i;
   assign flag_o = flag_q;

   if (KIND == LANE_GEN) begin : g_gen
      logic gen_unused;
      assign gen_unused = par_i;
      assign par_o    = even_ones(64'(data_q), DATA_W);
      assign par_oe_o = ~oe_n_i;
      assign err_n_o  = 1'b1;
   end else begin : g_chk
      logic par_q;
      logic [FULL_W-1:0] word;
      always_ff @(posedge clk) begin
         if (rst) begin
            par_q <= 1'b0;
         end else if (load) begin
            par_q <= par_i;
         end
      end
      assign word     = {par_q, data_q};
      assign par_o    = 1'b0;
      assign par_oe_o = 1'b0;
      assign err_n_o  = oe_n_i | ~even_ones(64'(word), FULL_W);
   end

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (stb_i && !$past(stb_i) && !ce_n_i) |=> (q_o == $past(d_i)));

   // R11
   no_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!stb_i || $past(stb_i) || ce_n_i) |=> $stable(q_o));

   // R4
   flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      (stb_i && !$past(stb_i) && !ce_n_i) |=> flag_o);

   // R5
   flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (oe_n_i && !$past(oe_n_i) && !(stb_i && !$past(stb_i) && !ce_n_i)) |=> !flag_o);

   // R5
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!(oe_n_i && !$past(oe_n_i)) && !(stb_i && !$past(stb_i) && !ce_n_i)) |=> $stable(flag_o));

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_drive,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_drive,
   input  logic              pbit_in,
   output logic              pbit_out,
   output logic              pbit_drive,
   input  logic              r_strobe,
   input  logic              r_load_n,
   input  logic              s_strobe,
   input  logic              s_load_n,
   input  logic              b_out_n,
   input  logic              a_out_n,
   output logic              r_full,
   output logic              s_full,
   output logic              perr_n
);

   logic r_par_oe;
   logic r_err_n;
   logic s_par;
   logic s_par_oe;

   // Forward direction: side A into register, out on side B with parity
   xcvr_lane #(.DATA_W(DATA_W), .KIND(LANE_GEN)) i_fwd (
      .clk(clk), .rst(rst),
      .stb_i(r_strobe), .ce_n_i(r_load_n), .oe_n_i(b_out_n),
      .d_i(a_in), .par_i(1'b0),
      .q_o(b_out), .q_oe_o(b_drive), .flag_o(r_full),
      .par_o(pbit_out), .par_oe_o(r_par_oe), .err_n_o(r_err_n)
   );

   // Return direction: side B plus parity in, out on side A with check
   xcvr_lane #(.DATA_W(DATA_W), .KIND(LANE_CHK)) i_ret (
      .clk(clk), .rst(rst),
      .stb_i(s_strobe), .ce_n_i(s_load_n), .oe_n_i(a_out_n),
      .d_i(b_in), .par_i(pbit_in),
      .q_o(a_out), .q_oe_o(a_drive), .flag_o(s_full),
      .par_o(s_par), .par_oe_o(s_par_oe), .err_n_o(perr_n)
   );

   assign pbit_drive = r_par_oe;

   logic top_unused;
   assign top_unused = r_err_n ^ s_par ^ s_par_oe;

   // R7
   pbit_drive_match_chk: assert property (@(posedge clk) disable iff (rst)
      pbit_drive == b_drive);

endmodule

// File: tb/test_dual_reg_xcvr.sv
module test_dual_reg_xcvr;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         pbit_in = 1'b0;
   logic         r_strobe = 1'b0, r_load_n = 1'b1;
   logic         s_strobe = 1'b0, s_load_n = 1'b1;
   logic         b_out_n = 1'b1, a_out_n = 1'b1;
   logic [W-1:0] a_out, b_out;
   logic         a_drive, b_drive, pbit_out, pbit_drive;
   logic         r_full, s_full, perr_n;

   int vectors = 0;
   int miscompares = 0;

   always #5 clk = ~clk;

   dual_reg_xcvr #(.DATA_W(W)) i_dual_reg_xcvr (
      .clk(clk), .rst(rst),
      .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
      .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
      .pbit_in(pbit_in), .pbit_out(pbit_out), .pbit_drive(pbit_drive),
      .r_strobe(r_strobe), .r_load_n(r_load_n),
      .s_strobe(s_strobe), .s_load_n(s_load_n),
      .b_out_n(b_out_n), .a_out_n(a_out_n),
      .r_full(r_full), .s_full(s_full), .perr_n(perr_n)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ones(input logic [31:0] v);
      int n = 0;
      for (int i = 0; i < 32; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic load_r(input logic [W-1:0] v);
      a_in = v; r_load_n = 1'b0; r_strobe = 1'b1;
      step();
      r_strobe = 1'b0; r_load_n = 1'b1;
   endtask

   task automatic load_s(input logic [W-1:0] v, input logic p);
      b_in = v; pbit_in = p; s_load_n = 1'b0; s_strobe = 1'b1;
      step();
      s_strobe = 1'b0; s_load_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1;
      repeat (3) step();
      rst = 1'b0;
      step();
      // R1 reset state
      check("R1 r_full", 32'(r_full), 0);
      check("R1 s_full", 32'(s_full), 0);
      b_out_n = 1'b0; a_out_n = 1'b0;
      #1;
      check("R1 b_out", 32'(b_out), 0);
      check("R1 a_out", 32'(a_out), 0);
      check("R8 pbit_out zero", 32'(pbit_out), 1);
      check("R10 perr_n zero", 32'(perr_n), 0);
      step();

      // R2 R4 R7 R8 forward sweep
      for (int v = 0; v < 256; v++) begin
         load_r(W'(v));
         check("R2 b_out", 32'(b_out), 32'(v));
         check("R4 r_full", 32'(r_full), 1);
         check("R7 b_drive", 32'(b_drive), 1);
         check("R7 pbit_drive", 32'(pbit_drive), 1);
         check("R8 pbit_out", 32'(pbit_out), 32'((ones(32'(v)) % 2) == 0));
         step();
      end

      // R3 R9 R10 return sweep
      for (int v = 0; v < 512; v++) begin
         load_s(W'(v), v[8]);
         check("R3 a_out", 32'(a_out), 32'(v & 255));
         check("R4 s_full", 32'(s_full), 1);
         check("R9 a_drive", 32'(a_drive), 1);
         check("R10 perr_n", 32'(perr_n), 32'((ones(32'(v)) % 2) == 1));
         step();
      end

      // R10 idle level, R9 drive off
      a_out_n = 1'b1;
      load_s(8'h00, 1'b0);
      check("R10 perr_n idle", 32'(perr_n), 1);
      check("R9 a_drive off", 32'(a_drive), 0);
      step();
      // a_out_n rose earlier; reload set flag again, now release clears? flag set by load
      check("R4 s_full after idle load", 32'(s_full), 1);

      // R5 clear forward flag on b_out_n rise
      b_out_n = 1'b1;
      #1;
      check("R7 b_drive off", 32'(b_drive), 0);
      check("R7 pbit_drive off", 32'(pbit_drive), 0);
      step();
      check("R5 r_full cleared", 32'(r_full), 0);
      // return flag: drive low then release
      a_out_n = 1'b0; step();
      check("R5 s_full holds while low", 32'(s_full), 1);
      a_out_n = 1'b1; step();
      check("R5 s_full cleared", 32'(s_full), 0);

      // R2 hold with load enable high
      b_out_n = 1'b0;
      load_r(8'h5A);
      step();
      a_in = 8'hC3; r_load_n = 1'b1; r_strobe = 1'b1;
      step();
      r_strobe = 1'b0;
      step();
      check("R2 hold when disabled", 32'(b_out), 32'h5A);

      // R11 held strobe stores once
      a_in = 8'h11; r_load_n = 1'b0; r_strobe = 1'b1;
      step();
      a_in = 8'h22; step();
      a_in = 8'h33; step();
      r_strobe = 1'b0; r_load_n = 1'b1;
      step();
      check("R11 single capture", 32'(b_out), 32'h11);

      // R6 set wins over clear in same cycle (b_out_n low beforehand)
      b_out_n = 1'b1; step();
      check("R5 r_full cleared again", 32'(r_full), 0);
      b_out_n = 1'b0; step();
      b_out_n = 1'b1; a_in = 8'h77; r_load_n = 1'b0; r_strobe = 1'b1;
      step();
      r_strobe = 1'b0; r_load_n = 1'b1;
      check("R6 r_full set wins", 32'(r_full), 1);
      a_out_n = 1'b0; step();
      a_out_n = 1'b1; b_in = 8'h0F; pbit_in = 1'b1; s_load_n = 1'b0; s_strobe = 1'b1;
      step();
      s_strobe = 1'b0; s_load_n = 1'b1;
      check("R6 s_full set wins", 32'(s_full), 1);
      a_out_n = 1'b0; #1;
      check("R3 parity captured", 32'(perr_n), 1);
      check("R3 a_out", 32'(a_out), 32'h0F);

      // R1 reset clears loaded state
      rst = 1'b1; step(); rst = 1'b0; step();
      check("R1 r_full after reset", 32'(r_full), 0);
      check("R1 a_out after reset", 32'(a_out), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule